// File: doc/BRIEF.md
# Converter Fault and Hiccup Sequencer

This block is the digital supervisor placed beside the analog front end of a single-phase switching converter. It receives one tick per switching period, one tick at the end of each soft-start ramp, and the comparator flags for current limit, feedback undervoltage, feedback overvoltage, thermal warning, thermal shutdown and thermal recovery. From these it decides whether the power stage may switch, when the low-side switch is forced on as a crowbar, whether the soft-start capacitor charges or discharges, and when power-good must be pulled low.

A current-limit condition only counts as a fault once it persists across a fixed number of switching periods in a row. Overcurrent and undervoltage both lead to a hiccup: a fixed run of blank soft-start charge and discharge cycles with the stage idle, then a fresh restart, repeated for as long as the fault returns. Overvoltage holds the low-side switch on until the feedback sinks to the undervoltage level and then joins the same hiccup path. Thermal shutdown stops the stage and lets it resume only after the recovery flag reports that the die has cooled. A fault-cause code stays visible until a restart reaches the end of its soft-start ramp.

Top module: `conv_fault_seq`

## Requirements
- R1: While running, the block counts switching ticks on which `ilim_over` is high; a tick with `ilim_over` low clears the count, and cycles without a tick leave it alone. On the 7th consecutive such tick the block enters hiccup in the next cycle with `fault_code` = 1 (overcurrent).
- R2: In hiccup, `hs_en`, `ls_en` and `sw_en` are 0; `ss_charge` is 1 on entry and toggles on every `ss_done` tick. The 14th tick (end of the 7th charge/discharge cycle) returns the block to running in the next cycle, where `hs_en`, `ls_en`, `sw_en` and `ss_charge` are all 1.
- R3: A fault after a restart starts a new hiccup again; the number of retries is unlimited.
- R4: `fb_uv` while running stops both switches and enters hiccup in the next cycle with `fault_code` = 2 (undervoltage).
- R5: `fb_ov` while running or in hiccup enters crowbar in the next cycle: `hs_en` = 0, `ls_en` = 1, `sw_en` = 0, `ss_charge` = 0, `fault_code` = 3 (overvoltage). Crowbar holds, even after `fb_ov` falls, until `fb_uv` is high, then hiccup follows with the code kept at 3. `fb_ov` takes priority over `fb_uv`.
- R6: `temp_shut` while running, in hiccup or in crowbar stops everything in the next cycle with `fault_code` = 4 (thermal). The block leaves the thermal stop only after `temp_cool` has been high with `temp_shut` low; it is running again two cycles after that edge.
- R7: `pg_low` is 1 whenever `temp_warn` is high, the thermal stop latch is set, or the block is not in the running state.
- R8: `fault_code` keeps its value until an `ss_done` tick occurs while running, which sets it to 0 (none); it is also 0 while disabled.
- R9: `enable` low puts the block in idle from any state in the next cycle, with all switch and soft-start outputs 0 and `fault_code` = 0; `enable` high in idle starts running in the next cycle.
- R10: After reset, `hs_en`, `ls_en`, `sw_en`, `ss_charge` are 0, `pg_low` is 1 and `fault_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| ss_done | input | 1 | One-cycle pulse when a soft-start ramp (up or down) ends |
| ilim_over | input | 1 | Current-limit comparator tripped |
| fb_uv | input | 1 | Feedback below undervoltage level |
| fb_ov | input | 1 | Feedback above overvoltage level |
| temp_warn | input | 1 | Die temperature above warning level |
| temp_shut | input | 1 | Die temperature above shutdown level |
| temp_cool | input | 1 | Die temperature below recovery level |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |
| sw_en | output | 1 | PWM switching enable |
| ss_charge | output | 1 | Soft-start capacitor: 1 charge, 0 discharge |
| pg_low | output | 1 | Request to pull power-good low |
| fault_code | output | 3 | Last fault cause: 0 none, 1 overcurrent, 2 undervoltage, 3 overvoltage, 4 thermal |

## Verification
Every switch, soft-start and fault output comes straight from the registered state, so each is due one clock after the edge that samples the stimulus; `pg_low` additionally follows `temp_warn` in the same cycle. The thermal recovery passes through one extra register, the cool-down latch, so the return to running is due two clocks after `temp_cool`. The bench drives inputs on the falling edge, lets one rising edge pass and compares all outputs on the next falling edge, so each check lands exactly in the cycle the result is due; the persistence and hiccup counts are checked one tick short of their limits and again at them.

// File: rtl/fsq_pkg.sv
// Package: shared state and fault-cause encodings for the fault sequencer.
// Assumes: fault_code encodings are visible at the top-level port.
package fsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_HICCUP  = 3'd2,
        ST_CROWBAR = 3'd3,
        ST_THERM   = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_OC    = 3'd1,
        FLT_UV    = 3'd2,
        FLT_OV    = 3'd3,
        FLT_THERM = 3'd4
    } fault_e;

endpackage

// File: rtl/fsq_oc_persist.sv
// Module: counts consecutive switching periods with the current limit tripped.
// Assumes: sw_tick is a one-cycle pulse; counting is only meaningful while
// active is high, and the count clears whenever active is low.
module fsq_oc_persist #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sw_tick,
    input  logic ilim_over,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Trip on the tick that completes the persistence run.
    assign trip = active && sw_tick && ilim_over && (cnt_q == LAST);

    // Advance on tripped ticks, clear on clean ticks or when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (sw_tick) begin
            if (!ilim_over || cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsq_hiccup_timer.sv
// Module: sequences the blank soft-start cycles of a hiccup.
// Assumes: ss_done pulses once at the end of each charge ramp and once at
// the end of each discharge ramp; a cycle is one charge plus one discharge.
module fsq_hiccup_timer #(
    parameter int CYCLES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ss_done,
    output logic charge,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cyc_q;
    logic          charge_q;

    assign charge = charge_q;
    // Done at the end of the discharge ramp of the final cycle.
    assign done   = active && ss_done && !charge_q && (cyc_q == LAST);

    // Alternate charge and discharge, counting completed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cyc_q    <= '0;
            charge_q <= 1'b1;
        end else if (ss_done) begin
            charge_q <= !charge_q;
            if (!charge_q && cyc_q != LAST) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsq_thermal.sv
// Module: thermal hysteresis latch.
// Assumes: temp_shut and temp_cool come from separate comparators; the
// shutdown flag dominates if both are seen together.
module fsq_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_shut,
    input  logic temp_cool,
    output logic hot
);
    logic hot_q;

    assign hot = hot_q;

    // Set on shutdown level, clear only once recovery level is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (temp_shut) begin
            hot_q <= 1'b1;
        end else if (temp_cool) begin
            hot_q <= 1'b0;
        end
    end
endmodule

// File: rtl/conv_fault_seq.sv
// Module: converter fault supervisor and hiccup sequencer (top).
// Handles overcurrent persistence, hiccup restarts, overvoltage crowbar,
// undervoltage shutdown and thermal stop with hysteresis.
// Assumes: all flag inputs are already synchronous to clk; ticks are
// single-cycle pulses. Outputs decode the registered state only, except
// pg_low which also follows temp_warn directly.
module conv_fault_seq
    import fsq_pkg::*;
#(
    parameter int OC_LIMIT      = 7,
    parameter int HICCUP_CYCLES = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sw_tick,
    input  logic       ss_done,
    input  logic       ilim_over,
    input  logic       fb_uv,
    input  logic       fb_ov,
    input  logic       temp_warn,
    input  logic       temp_shut,
    input  logic       temp_cool,
    output logic       hs_en,
    output logic       ls_en,
    output logic       sw_en,
    output logic       ss_charge,
    output logic       pg_low,
    output logic [2:0] fault_code
);
    seq_state_e state_q, state_d;
    fault_e     code_q, code_d;

    logic oc_trip;
    logic hic_charge;
    logic hic_done;
    logic hot;

    fsq_oc_persist #(.LIMIT(OC_LIMIT)) u_oc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_RUN),
        .sw_tick   (sw_tick),
        .ilim_over (ilim_over),
        .trip      (oc_trip)
    );

    fsq_hiccup_timer #(.CYCLES(HICCUP_CYCLES)) u_hic (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == ST_HICCUP),
        .ss_done (ss_done),
        .charge  (hic_charge),
        .done    (hic_done)
    );

    fsq_thermal u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_shut (temp_shut),
        .temp_cool (temp_cool),
        .hot       (hot)
    );

    // Next-state and fault-cause decision, priority thermal > OV > UV > OC.
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (!enable) begin
            state_d = ST_IDLE;
            code_d  = FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hot || temp_shut) begin
                        state_d = ST_THERM;
                        code_d  = FLT_THERM;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (temp_shut) begin
                        state_d = ST_THERM;
                        code_d  = FLT_THERM;
                    end else if (fb_ov) begin
                        state_d = ST_CROWBAR;
                        code_d  = FLT_OV;
                    end else if (fb_uv) begin
                        state_d = ST_HICCUP;
                        code_d  = FLT_UV;
                    end else if (oc_trip) begin
                        state_d = ST_HICCUP;
                        code_d  = FLT_OC;
                    end else if (ss_done) begin
                        code_d  = FLT_NONE;
                    end
                end
                ST_HICCUP: begin
                    if (temp_shut) begin
                        state_d = ST_THERM;
                        code_d  = FLT_THERM;
                    end else if (fb_ov) begin
                        state_d = ST_CROWBAR;
                        code_d  = FLT_OV;
                    end else if (hic_done) begin
                        state_d = ST_RUN;
                    end
                end
                ST_CROWBAR: begin
                    if (temp_shut) begin
                        state_d = ST_THERM;
                        code_d  = FLT_THERM;
                    end else if (fb_uv) begin
                        state_d = ST_HICCUP;
                    end
                end
                ST_THERM: begin
                    if (!hot) begin
                        state_d = ST_RUN;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    code_d  = FLT_NONE;
                end
            endcase
        end
    end

    // State and fault-cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= FLT_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        hs_en     = 1'b0;
        ls_en     = 1'b0;
        sw_en     = 1'b0;
        ss_charge = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                hs_en     = 1'b1;
                ls_en     = 1'b1;
                sw_en     = 1'b1;
                ss_charge = 1'b1;
            end
            ST_HICCUP:  ss_charge = hic_charge;
            ST_CROWBAR: ls_en     = 1'b1;
            default: ;
        endcase
    end

    // Power-good low on warning, thermal latch, or any non-running state.
    assign pg_low     = temp_warn || hot || (state_q != ST_RUN);
    assign fault_code = code_q;

endmodule

// File: rtl/fsq_checker.sv
// Module: property checker for conv_fault_seq, attached by bind.
// Assumes: observes top-level ports only.
module fsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       ss_done,
    input logic       fb_uv,
    input logic       fb_ov,
    input logic       temp_warn,
    input logic       temp_shut,
    input logic       hs_en,
    input logic       ls_en,
    input logic       sw_en,
    input logic       pg_low,
    input logic [2:0] fault_code
);
    // R9: disable forces everything off one cycle later.
    a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_en && !ls_en && !sw_en && fault_code == 3'd0));

    // R5: overvoltage while running turns on the crowbar.
    a_r5_ov_crowbar: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sw_en && fb_ov && !temp_shut) |=> (ls_en && !hs_en && !sw_en));

    // R4: undervoltage while running stops both switches.
    a_r4_uv_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sw_en && fb_uv && !fb_ov && !temp_shut) |=> (!hs_en && !ls_en && fault_code == 3'd2));

    // R6: thermal shutdown stops the stage.
    a_r6_therm_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && temp_shut) |=> (!hs_en && !ls_en && !sw_en));

    // R7: thermal warning always requests power-good low.
    a_r7_warn_pg: assert property (@(posedge clk) disable iff (!rst_n)
        temp_warn |-> pg_low);

    // R8: a fault cause is only cleared by a completed soft-start or disable.
    a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fault_code != 3'd0 && !(sw_en && ss_done)) |=> fault_code != 3'd0);
endmodule

bind conv_fault_seq fsq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .ss_done    (ss_done),
    .fb_uv      (fb_uv),
    .fb_ov      (fb_ov),
    .temp_warn  (temp_warn),
    .temp_shut  (temp_shut),
    .hs_en      (hs_en),
    .ls_en      (ls_en),
    .sw_en      (sw_en),
    .pg_low     (pg_low),
    .fault_code (fault_code)
);

// File: tb/sim_conv_fault_seq.sv
module sim_conv_fault_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, sw_tick = 1'b0, ss_done = 1'b0, ilim_over = 1'b0;
    logic fb_uv = 1'b0, fb_ov = 1'b0, temp_warn = 1'b0, temp_shut = 1'b0, temp_cool = 1'b0;
    logic hs_en, ls_en, sw_en, ss_charge, pg_low;
    logic [2:0] fault_code;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = !clk;

    conv_fault_seq u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sw_tick(sw_tick),
        .ss_done(ss_done), .ilim_over(ilim_over), .fb_uv(fb_uv), .fb_ov(fb_ov),
        .temp_warn(temp_warn), .temp_shut(temp_shut), .temp_cool(temp_cool),
        .hs_en(hs_en), .ls_en(ls_en), .sw_en(sw_en), .ss_charge(ss_charge),
        .pg_low(pg_low), .fault_code(fault_code)
    );

    // Vector: inputs {en,swt,ssd,ilim,uv,ov,tshut,tcool,twarn}
    //         expected {hs,ls,sw,ss,pg,code[2:0]}
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        17'b1_0_0_0_0_0_0_0_0_1_1_1_1_0_000, // R9 start running
        17'b1_0_0_0_0_1_0_0_0_0_1_0_0_1_011, // R5 crowbar
        17'b1_0_0_0_0_0_0_0_0_0_1_0_0_1_011, // R5 crowbar held
        17'b1_0_0_0_1_0_0_0_0_0_0_0_1_1_011, // R5 uv -> hiccup, code kept
        17'b1_0_0_0_0_1_0_0_0_0_1_0_0_1_011, // R5 ov in hiccup
        17'b1_0_0_0_1_0_0_0_0_0_0_0_1_1_011, // R5 back to hiccup
        17'b1_0_0_0_0_0_1_0_0_0_0_0_0_1_100, // R6 thermal stop
        17'b1_0_0_0_0_0_0_0_0_0_0_0_0_1_100, // R6 held
        17'b1_0_0_0_0_0_0_1_0_0_0_0_0_1_100, // R6 cool seen, latch clears
        17'b1_0_0_0_0_0_0_0_0_1_1_1_1_0_100, // R6 running again, R8 code held
        17'b1_0_1_0_0_0_0_0_0_1_1_1_1_0_000, // R8 soft-start end clears
        17'b1_0_0_0_0_0_0_0_1_1_1_1_1_1_000, // R7 warning
        17'b1_0_0_0_0_0_0_0_0_1_1_1_1_0_000, // R7 warning gone
        17'b0_0_0_0_0_0_0_0_0_0_0_0_0_1_000  // R9 disable
    };

    task automatic drive(input logic [8:0] v);
        {enable, sw_tick, ss_done, ilim_over, fb_uv, fb_ov, temp_shut, temp_cool, temp_warn} = v;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {hs_en, ls_en, sw_en, ss_charge, pg_low, fault_code};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset", 8'b0000_1_000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", 8'b0000_1_000);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16:8]);
            chk($sformatf("table row %0d", i), VEC[i][7:0]);
        end

        // R1: persistence count, reset by a clean tick
        drive(9'b1_0_0_0_0_0_0_0_0);
        chk("R9 enable", 8'b1111_0_000);
        for (int i = 0; i < 6; i++) drive(9'b1_1_0_1_0_0_0_0_0);
        drive(9'b1_0_0_1_0_0_0_0_0);
        chk("R1 six ticks plus idle cycle", 8'b1111_0_000);
        drive(9'b1_1_0_0_0_0_0_0_0);
        for (int i = 0; i < 6; i++) drive(9'b1_1_0_1_0_0_0_0_0);
        chk("R1 count cleared, six again", 8'b1111_0_000);
        drive(9'b1_1_0_1_0_0_0_0_0);
        chk("R1 seventh tick trips", 8'b0001_1_001);

        // R2: fourteen soft-start ticks
        drive(9'b1_0_1_0_0_0_0_0_0);
        chk("R2 discharge after first tick", 8'b0000_1_001);
        for (int i = 0; i < 12; i++) drive(9'b1_0_1_0_0_0_0_0_0);
        chk("R2 still blank after 13 ticks", 8'b0000_1_001);
        drive(9'b1_0_1_0_0_0_0_0_0);
        chk("R2 restart after 14 ticks", 8'b1111_0_001);
        drive(9'b1_0_0_0_0_0_0_0_0);
        chk("R8 code held while ramping", 8'b1111_0_001);
        drive(9'b1_0_1_0_0_0_0_0_0);
        chk("R8 cleared by soft-start end", 8'b1111_0_000);

        // R3: fault again -> new hiccup
        for (int i = 0; i < 7; i++) drive(9'b1_1_0_1_0_0_0_0_0);
        chk("R3 second hiccup", 8'b0001_1_001);
        drive(9'b0_0_0_0_0_0_0_0_0);
        chk("R9 disable from hiccup", 8'b0000_1_000);

        // R4: undervoltage
        drive(9'b1_0_0_0_0_0_0_0_0);
        drive(9'b1_0_0_0_1_0_0_0_0);
        chk("R4 uv enters hiccup", 8'b0001_1_010);

        // R5: ov beats uv, R9 from crowbar
        drive(9'b1_0_0_0_1_1_0_0_0);
        chk("R5 ov priority in hiccup", 8'b0100_1_011);
        drive(9'b0_0_0_0_0_0_0_0_0);
        chk("R9 disable from crowbar", 8'b0000_1_000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule